// File: doc/BRIEF.md
# Byte-Programmable Code Array Sequencer

This block sequences programming of a small on-chip nonvolatile code store, held here as a register array. A host drives a parallel port (address, write byte, a three-bit mode code and an active-low strobe) and watches a ready line and a read-back byte. A falling strobe edge in program mode starts a self-timed byte write. In erase mode the strobe must stay low for a timed span to wipe the whole store. Other modes give read-back for verification, lock-bit programming, and a fixed identification view.

The controller has three states. `ST_IDLE` accepts commands. `ST_WRITE` times a byte or lock write. `ST_ERASE` times a held erase. The transitions are: IDLE to WRITE on an accepted program or lock command; IDLE to ERASE on an erase command; WRITE to IDLE when the write timer expires; ERASE to IDLE when the erase timer expires with the strobe still low, or early (abort) when the strobe rises. A program command aimed at a byte that is not blank is refused in IDLE, and the state does not change.

Mode codes: 0 read, 1 byte program, 2 chip erase, 3 signature, 4 lock program; 5 to 7 are unused. The write and erase spans are parameters, so a short simulation can use short spans.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset every address reads 0xFF in read mode (code 0), `ready` is high and `err` is low.
- R2: With mode 1, a strobe falling edge on a blank byte (0xFF) takes `ready` low for exactly WRITE_CYC cycles. After that the byte reads back the value that was on `din` at the edge.
- R3: During a byte write, a read (mode 0) at the target address returns the inverse of the written bit 7 on `dout[7]`, and the still-blank value (all ones) on `dout[6:0]`. Reads at other addresses return their stored bytes.
- R4: A strobe falling edge while `ready` is low has no effect on the store or on the timing of the write in progress.
- R5: A mode 1 command aimed at a byte other than 0xFF leaves the store unchanged, keeps `ready` high and sets `err`. The next accepted command clears `err`.
- R6: With mode 2, `ready` goes low from the strobe falling edge. If the strobe stays low for ERASE_CYC cycles, every byte becomes 0xFF and all three lock bits clear. If the strobe rises earlier, the erase is aborted and nothing changes.
- R7: With mode 4, a strobe falling edge sets lock bits from `din[2:0]` (`din[0]` sets lock 1, `din[1]` sets lock 2, `din[2]` sets lock 3), and `ready` is low for WRITE_CYC cycles. Only an erase clears the lock bits.
- R8: While lock 2 is set, read mode returns 0xFF at every address.
- R9: While lock 1 is set, mode 1 commands are refused exactly as in R5.
- R10: In mode 3, address 0x30 returns 0x1E, 0x31 returns 0x51, 0x32 returns parameter SIG_VPP (default 0xFF), and any other address returns 0xFF.
- R11: In modes 1, 2, 4 and the unused codes 5 to 7, `dout` is 0xFF. A strobe edge in an unused mode starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program, or lock mask |
| mode | input | 3 | Mode code |
| strobe_n | input | 1 | Active-low command strobe |
| dout | output | 8 | Read-back byte |
| ready | output | 1 | High when idle, low while busy |
| err | output | 1 | Last program command was refused |

## Verification
The main function is exercised by programming every address in turn with an arithmetic pattern whose bit 7 varies. This shows both polarities of the polled bit. It also separates the cycle-exact busy length from a store that merely ends up correct. Refused writes (a non-blank target and lock 1) are contrasted with accepted ones, which shows that `err` and the store react only in the refused case. A strobe edge fired during a write, and an erase released early, are each compared with a completed erase; this shows that commands are ignored while busy and that an aborted erase changes nothing. The signature view, read gating by lock 2 and the unused mode codes are swept by address and by mode.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MD_READ  = 3'd0,
        MD_PROG  = 3'd1,
        MD_ERASE = 3'd2,
        MD_SIG   = 3'd3,
        MD_LOCK  = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_ERASE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else            count <= count + 1'b1;
    end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    assert_blank_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mem[wr_addr] == 8'hFF));

    assert_erase_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/nvm_read_mux.sv
module nvm_read_mux
    import nvm_seq_pkg::*;
#(
    parameter int         ADDR_W  = 6,
    parameter logic [7:0] SIG_VPP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        mem_q,
    input  logic              polling,
    input  logic              poll_bit,
    input  logic              hide_code,
    output logic [7:0]        dout
);
    logic [31:0] addr_x;
    assign addr_x = 32'(addr);

    always_comb begin
        dout = 8'hFF;
        if (mode == MD_SIG) begin
            unique case (addr_x)
                32'h30:  dout = 8'h1E;
                32'h31:  dout = 8'h51;
                32'h32:  dout = SIG_VPP;
                default: dout = 8'hFF;
            endcase
        end else if (mode == MD_READ && !hide_code) begin
            if (polling) dout = {~poll_bit, mem_q[6:0]};
            else         dout = mem_q;
        end
    end

    assert_poll_inverts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ && polling && !hide_code) |-> (dout[7] == ~poll_bit));

    assert_sig_vendor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SIG && addr_x == 32'h30) |-> (dout == 8'h1E));

    assert_lock_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ && hide_code) |-> (dout == 8'hFF));

    assert_other_modes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_READ && mode != MD_SIG) |-> (dout == 8'hFF));
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
    import nvm_seq_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         WRITE_CYC = 20,
    parameter int         ERASE_CYC = 40,
    parameter logic [7:0] SIG_VPP   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [2:0]        mode,
    input  logic              strobe_n,
    output logic [7:0]        dout,
    output logic              ready,
    output logic              err
);
    localparam int MAX_CYC = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    seq_state_e        state, state_nx;
    logic              strobe_q;
    logic              fall;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data;
    logic              lat_is_lock;
    logic [2:0]        lock;
    logic [7:0]        mem_q;
    logic              blank;
    logic              accept_prog, reject_prog, start_lock, start_erase;
    logic              done_w, done_e;
    logic              wr_en, erase_en, polling;

    assign fall        = strobe_q & ~strobe_n;
    assign blank       = (mem_q == 8'hFF);
    assign accept_prog = (state == ST_IDLE) && fall && (mode == MD_PROG) && blank && !lock[0];
    assign reject_prog = (state == ST_IDLE) && fall && (mode == MD_PROG) && !(blank && !lock[0]);
    assign start_lock  = (state == ST_IDLE) && fall && (mode == MD_LOCK);
    assign start_erase = (state == ST_IDLE) && fall && (mode == MD_ERASE);
    assign done_w      = (cnt == CW'(WRITE_CYC - 1));
    assign done_e      = (cnt == CW'(ERASE_CYC - 1)) && !strobe_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_prog || start_lock) state_nx = ST_WRITE;
                else if (start_erase)          state_nx = ST_ERASE;
            end
            ST_WRITE: if (done_w) state_nx = ST_IDLE;
            ST_ERASE: if (strobe_n || done_e) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = (state == ST_IDLE);
        wr_en    = (state == ST_WRITE) && done_w && !lat_is_lock;
        erase_en = (state == ST_ERASE) && done_e;
        polling  = (state == ST_WRITE) && !lat_is_lock && (addr == lat_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q    <= 1'b1;
            lat_addr    <= '0;
            lat_data    <= 8'hFF;
            lat_is_lock <= 1'b0;
            lock        <= '0;
            err         <= 1'b0;
        end else begin
            strobe_q <= strobe_n;
            if (accept_prog || start_lock) begin
                lat_addr    <= addr;
                lat_data    <= din;
                lat_is_lock <= start_lock;
            end
            if (reject_prog)                                   err <= 1'b1;
            else if (accept_prog || start_lock || start_erase) err <= 1'b0;
            if (erase_en)
                lock <= '0;
            else if (state == ST_WRITE && done_w && lat_is_lock)
                lock <= lock | lat_data[2:0];
        end
    end

    nvm_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE),
        .count (cnt)
    );

    nvm_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (addr),
        .rd_data  (mem_q),
        .wr_en    (wr_en),
        .wr_addr  (lat_addr),
        .wr_data  (lat_data),
        .erase_en (erase_en)
    );

    nvm_read_mux #(.ADDR_W(ADDR_W), .SIG_VPP(SIG_VPP)) u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .addr      (addr),
        .mem_q     (mem_q),
        .polling   (polling),
        .poll_bit  (lat_data[7]),
        .hide_code (lock[1]),
        .dout      (dout)
    );

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_prog |=> !ready);

    assert_busy_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(lat_addr) && $stable(lat_data)));

    assert_refuse_keeps_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reject_prog |=> (ready && err));
endmodule

// File: tb/sim_nvm_prog_seq.sv
module sim_nvm_prog_seq;
    localparam int AW = 6;
    localparam int WC = 20;
    localparam int EC = 40;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [2:0]    mode = 3'd0;
    logic          strobe_n = 1'b1;
    logic [7:0]    dout;
    logic          ready, err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvm_prog_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .SIG_VPP(8'hFF)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
        .strobe_n(strobe_n), .dout(dout), .ready(ready), .err(err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        mode = 3'd0; addr = a;
        #1 chk(req, dout, exp);
    endtask

    // strobe low for one cycle; returns at the negedge after the accepting edge
    task automatic pulse(logic [2:0] m, logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        mode = m; addr = a; din = d; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        #1 chk("R1 ready", ready, 1);
        chk("R1 err", err, 0);
        for (int a = 0; a < N; a++) rd(AW'(a), 8'hFF, "R1 erased");

        // R10 signature sweep
        for (int a = 0; a < N; a++) begin
            logic [7:0] e;
            e = (a == 'h30) ? 8'h1E : (a == 'h31) ? 8'h51 : 8'hFF;
            @(negedge clk); mode = 3'd3; addr = AW'(a);
            #1 chk("R10 signature", dout, e);
        end

        // R11 non-read modes give 0xFF
        for (int m = 1; m < 8; m++) begin
            if (m == 3) continue;
            @(negedge clk); mode = 3'(m); addr = 6'd7;
            #1 chk("R11 dout idle mode", dout, 8'hFF);
        end
        pulse(3'd6, 6'd7, 8'h00);
        #1 chk("R11 unused mode no start", ready, 1);

        // R2 / R3 program every byte
        for (int a = 0; a < N; a++) begin
            pulse(3'd1, AW'(a), pat(a));
            mode = 3'd0; addr = AW'(a);
            #1 chk("R3 poll bit7", dout, {~pat(a)[7], 7'h7F});
            addr = AW'((a + 1) % N);
            #1 chk("R3 other addr", dout, (a + 1 < N) ? 8'hFF : pat(0));
            wait_ready(n);
            chk("R2 busy length", n, WC);
            rd(AW'(a), pat(a), "R2 readback");
        end
        for (int a = 0; a < N; a++) rd(AW'(a), pat(a), "R2 full sweep");

        // R5 non-blank refused
        pulse(3'd1, 6'd3, 8'h00);
        #1 chk("R5 ready stays high", ready, 1);
        chk("R5 err set", err, 1);
        rd(6'd3, pat(3), "R5 byte unchanged");
        pulse(3'd4, 6'd0, 8'h00);
        wait_ready(n);
        chk("R5 err cleared", err, 0);

        // R6 aborted erase
        @(negedge clk); mode = 3'd2; strobe_n = 1'b0;
        @(negedge clk); #1 chk("R6 busy while held", ready, 0);
        repeat (4) @(negedge clk);
        strobe_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R6 abort ready", ready, 1);
        for (int a = 0; a < N; a++) rd(AW'(a), pat(a), "R6 abort keeps data");

        // R6 full erase
        @(negedge clk); mode = 3'd2; strobe_n = 1'b0;
        repeat (EC + 3) @(negedge clk);
        #1 chk("R6 erase done ready", ready, 1);
        strobe_n = 1'b1;
        for (int a = 0; a < N; a++) rd(AW'(a), 8'hFF, "R6 erased");

        // R4 command while busy ignored
        pulse(3'd1, 6'd10, 8'h12);
        @(negedge clk); mode = 3'd1; addr = 6'd11; din = 8'h34; strobe_n = 1'b0;
        @(negedge clk); strobe_n = 1'b1;
        n = 2;
        while (!ready && n < 1000) begin n++; @(negedge clk); end
        chk("R4 timing kept", n, WC);
        rd(6'd11, 8'hFF, "R4 ignored byte");
        rd(6'd10, 8'h12, "R4 write kept");

        // R7 / R9 lock 1
        pulse(3'd4, 6'd0, 8'h01);
        wait_ready(n);
        chk("R7 lock busy length", n, WC);
        pulse(3'd1, 6'd20, 8'h55);
        #1 chk("R9 refused ready", ready, 1);
        chk("R9 err", err, 1);
        rd(6'd20, 8'hFF, "R9 byte unchanged");
        rd(6'd10, 8'h12, "R7 lock1 keeps read");

        // R8 lock 2 hides code
        pulse(3'd4, 6'd0, 8'h02);
        wait_ready(n);
        rd(6'd10, 8'hFF, "R8 hidden");
        @(negedge clk); mode = 3'd3; addr = 6'h31;
        #1 chk("R8 signature still visible", dout, 8'h51);

        // R6 erase clears locks
        @(negedge clk); mode = 3'd2; strobe_n = 1'b0;
        repeat (EC + 3) @(negedge clk);
        strobe_n = 1'b1;
        pulse(3'd1, 6'd5, 8'h5A);
        wait_ready(n);
        chk("R6 lock1 cleared", err, 0);
        rd(6'd5, 8'h5A, "R6 lock2 cleared");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule